// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a bus that never needs an idle cycle between a read and a write. Each rising clock edge samples one command: a load of an external address for read or write, an advance of the internal burst address, or a deselect. The data for any command moves on the data bus exactly two clock edges after the command edge. Because the data bus always lags the commands by the same two edges, reads and writes can alternate on every cycle with no idle slot.

The tri-state bus is modelled with three ports: an output enable, an output data word and an input data word. The word is split into four 9-bit lanes. Each lane has its own active-low write strobe, and the strobes are sampled on the same edge as the write data. An active-low clock enable can block an edge. A blocked edge freezes every register in the block: the burst state, both pipeline stages, the memory and the bus outputs.

A burst steps the low two address bits in linear order and wraps within an aligned group of four words. The higher address bits stay fixed. A read issued one cycle after a write to the same word returns the newly written lanes, taken from the write that is still pending.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted, and on the first clock edge after reset is released, `bus_oe` is 0 (bus high-impedance).
- R2: A read load on edge k (`adv_burst`=0, chip selected, `rd_nwr`=1) drives `bus_oe`=1 after edge k+1, with the addressed word on `bus_out`. The word is therefore valid when edge k+2 samples it.
- R3: A write load on edge k (`rd_nwr`=0) stores `bus_in`, as sampled on edge k+2, into the addressed word.
- R4: On a write's data edge, lane n (bits 9n+8 down to 9n) is written only if `lane_wr_n[n]` is 0. Any mix of lanes may be written. With all four strobes at 1, the word is left unchanged.
- R5: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load edge (`adv_burst`=0) that is not selected is a deselect, and `bus_oe` is 0 two edges later.
- R6: An advance edge (`adv_burst`=1) following an active load or advance continues the burst in the direction set by the load. `rd_nwr` is ignored. The address becomes {upper bits unchanged, low 2 bits + 1 mod 4}.
- R7: An advance edge following a deselect, or following an advance that was itself a no-op, is a no-op. The bus stays high-impedance two edges later.
- R8: An edge with `ck_en_n`=1 is blocked. On such an edge `bus_oe`, `bus_out`, the burst state, the pending pipeline stages and the memory all keep their values.
- R9: A read issued on the edge right after a write to the same address returns the lanes that the write stores, merged with the unwritten lanes of the old word.
- R10: Read and write loads may alternate on consecutive edges, with no idle cycle between them, and each transfers correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_en_n | input | 1 | Active-low clock enable; 1 blocks the edge |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| adv_burst | input | 1 | 0 = load external address, 1 = advance burst |
| rd_nwr | input | 1 | 1 = read, 0 = write (on loads only) |
| lane_wr_n | input | 4 | Active-low per-lane write strobes, sampled with write data |
| addr | input | 6 | Word address |
| bus_in | input | 36 | Data bus, inbound half |
| bus_out | output | 36 | Data bus, outbound half |
| bus_oe | output | 1 | Bus drive enable; 0 = high-impedance |

## Verification
Every command's bus effect is due on the second enabled edge after the command edge. A read shows on `bus_out`/`bus_oe` right after the first following enabled edge, so a read issued on edge k is checked 1 ns after edge k+1. Write data and strobes are applied so that edge k+2 samples them. The bench drives inputs and samples outputs 1 ns after each edge, and counts only enabled edges when placing data. Suspend tests insert blocked edges inside these windows and confirm that the due edge moves by the number of edges blocked.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Kind of transfer a pipeline stage carries toward the bus
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

endpackage

// File: rtl/zbt_burst_ctl.sv
// Command decode and burst address state.
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              chip_sel,
  input  logic              adv_burst,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               op,
  output logic [ADDR_W-1:0] op_addr
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] step_addr;

  // Linear step inside the aligned group; upper bits held
  always_comb begin
    step_addr = {addr_q[ADDR_W-1 -: HI_W], addr_q[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1}};
  end

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    op      = OP_IDLE;
    op_addr = addr_in;
    if (!adv_burst) begin
      act_d  = chip_sel;
      wr_d   = !rd_nwr;
      addr_d = addr_in;
      if (chip_sel) op = rd_nwr ? OP_RD : OP_WR;
    end else begin
      op_addr = step_addr;
      if (act_q) begin
        addr_d = step_addr;
        op     = wr_q ? OP_WR : OP_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/zbt_pipe.sv
// Two-stage command pipeline between command edge and data edge.
module zbt_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr
);

  op_e               s1_op_d, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_d, s2_addr_d;

  always_comb begin
    s1_op_d   = s1_op;
    s1_addr_d = s1_addr;
    s2_op_d   = s2_op;
    s2_addr_d = s2_addr;
    if (en) begin
      s1_op_d   = op_in;
      s1_addr_d = addr_in;
      s2_op_d   = s1_op;
      s2_addr_d = s1_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
    end else begin
      s1_op   <= s1_op_d;
      s1_addr <= s1_addr_d;
      s2_op   <= s2_op_d;
      s2_addr <= s2_addr_d;
    end
  end

endmodule

// File: rtl/zbt_lane_array.sv
// Lane-sliced storage with per-lane write strobes and forwarding of the
// write that commits on the same edge as the read.
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic hit;
  assign hit = we && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !lane_wr_n[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = (hit && !lane_wr_n[g]) ? wdata[g*LANE_W +: LANE_W]
                                                              : mem[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ck_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    adv_burst,
  input  logic                    rd_nwr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              chip_sel;
  op_e               cmd_op, s1_op, s2_op;
  logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
  logic [DATA_W-1:0] rd_word;
  logic              oe_d;
  logic [DATA_W-1:0] out_d;
  logic              commit;

  assign en       = !ck_en_n;
  assign chip_sel = !sel_a_n && !sel_b_n && sel_c;
  assign commit   = en && (s2_op == OP_WR);

  zbt_burst_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .chip_sel (chip_sel),
    .adv_burst(adv_burst),
    .rd_nwr   (rd_nwr),
    .addr_in  (addr),
    .op       (cmd_op),
    .op_addr  (cmd_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .op_in  (cmd_op),
    .addr_in(cmd_addr),
    .s1_op  (s1_op),
    .s1_addr(s1_addr),
    .s2_op  (s2_op),
    .s2_addr(s2_addr)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .we       (commit),
    .wr_addr  (s2_addr),
    .wdata    (bus_in),
    .lane_wr_n(lane_wr_n),
    .rd_addr  (s1_addr),
    .rdata    (rd_word)
  );

  // Output stage: loaded from stage one so the word is on the bus for edge k+2
  always_comb begin
    oe_d  = bus_oe;
    out_d = bus_out;
    if (en) begin
      oe_d = (s1_op == OP_RD);
      if (s1_op == OP_RD) out_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= oe_d;
      bus_out <= out_d;
    end
  end

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ck_en_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              adv_burst,
  input logic              rd_nwr,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out
);

  // Port-level shadow of which edges must leave the bus driven
  logic m_act, m_wr, m_q1, m_q2;
  logic m_sel, m_rd;

  assign m_sel = !sel_a_n && !sel_b_n && sel_c;
  assign m_rd  = adv_burst ? (m_act && !m_wr) : (m_sel && rd_nwr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0;
      m_wr  <= 1'b0;
      m_q1  <= 1'b0;
      m_q2  <= 1'b0;
    end else if (!ck_en_n) begin
      if (!adv_burst) begin
        m_act <= m_sel;
        m_wr  <= !rd_nwr;
      end
      m_q1 <= m_rd;
      m_q2 <= m_q1;
    end
  end

  // R1
  reset_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_oe);

  // R8
  freeze_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_en_n |=> $stable(bus_oe));

  // R8
  freeze_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_en_n |=> $stable(bus_out));

  // R2 R5 R7
  oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == m_q2);

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ck_en_n  (ck_en_n),
  .sel_a_n  (sel_a_n),
  .sel_b_n  (sel_b_n),
  .sel_c    (sel_c),
  .adv_burst(adv_burst),
  .rd_nwr   (rd_nwr),
  .bus_oe   (bus_oe),
  .bus_out  (bus_out)
);

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ck_en_n, sel_a_n, sel_b_n, sel_c, adv_burst, rd_nwr;
  logic [3:0]  lane_wr_n;
  logic [5:0]  addr;
  logic [35:0] bus_in, bus_out;
  logic        bus_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  zbt_sram u0 (
    .clk(clk), .rst_n(rst_n), .ck_en_n(ck_en_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .adv_burst(adv_burst), .rd_nwr(rd_nwr),
    .lane_wr_n(lane_wr_n), .addr(addr), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe)
  );

  typedef struct packed {
    logic        cen_n;
    logic        sa_n;
    logic        sb_n;
    logic        sc;
    logic        adv;
    logic        rnw;
    logic [3:0]  bw_n;
    logic [5:0]  a;
    logic [35:0] d;
    logic        e_oe;
    logic [35:0] e_out;
    logic [3:0]  req;
  } vec_t;

  localparam logic [35:0] DA = 36'h123456789, DB = 36'hABCDEF012, DC = 36'h0F0F0F0F0;
  localparam logic [35:0] DD = 36'h555555555, DE = 36'hAAAAAAAAA, DF = 36'h876543210;
  localparam int NV = 17;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'hF, 6'd4, 36'h0, 1'b0, 36'h0, 4'd3},  // R3 load write 4
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'hF, 6'd5, 36'h0, 1'b0, 36'h0, 4'd3},  // R3 load write 5
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 4'h0, 6'd4, DA,    1'b0, 36'h0, 4'd10}, // R10 read after write
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 4'h0, 6'd5, DB,    1'b1, DA,    4'd2},  // R2 word 4 out
    '{1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1, 4'hF, 6'd0, 36'h0, 1'b1, DB,    4'd10}, // R10 deselect
    '{1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd5},  // R5 advance after deselect
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd7},  // R7 still no-op
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'hF, 6'd6, 36'h0, 1'b0, 36'h0, 4'd7},  // R7 burst write at 6
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd6},  // R6 advance, rd_nwr ignored
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'h0, 6'd0, DC,    1'b0, 36'h0, 4'd6},  // R6 wrap to 4
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'h0, 6'd0, DD,    1'b0, 36'h0, 4'd6},
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 4'h0, 6'd6, DE,    1'b0, 36'h0, 4'd6},  // R6 burst read at 6
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'h0, 6'd0, DF,    1'b1, DC,    4'd6},
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'hF, 6'd0, 36'h0, 1'b1, DD,    4'd6},
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'hF, 6'd0, 36'h0, 1'b1, DE,    4'd6},  // R6 wrapped word
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'hF, 6'd0, 36'h0, 1'b1, DF,    4'd6},
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd5}   // R5 deselect took effect
  };

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic cen, input logic sel, input logic adv, input logic rnw,
                    input logic [5:0] a, input logic [35:0] d, input logic [3:0] bw);
    ck_en_n = cen; sel_a_n = !sel; sel_b_n = 1'b0; sel_c = 1'b1;
    adv_burst = adv; rd_nwr = rnw; addr = a; bus_in = d; lane_wr_n = bw;
    @(posedge clk); #1;
  endtask

  function automatic logic [35:0] lane_mask(input logic [3:0] bw);
    logic [35:0] m = '0;
    for (int n = 0; n < 4; n++) if (!bw[n]) m[n*9 +: 9] = 9'h1FF;
    return m;
  endfunction

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ck_en_n = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b0; sel_c = 1'b1;
    adv_burst = 1'b0; rd_nwr = 1'b1; addr = '0; bus_in = '0; lane_wr_n = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 during reset", {35'b0, bus_oe}, 36'h0);
    rst_n = 1'b1;
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);  // R1 read issued on first edge
    chk("R1 first edge", {35'b0, bus_oe}, 36'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      ck_en_n = VEC[i].cen_n; sel_a_n = VEC[i].sa_n; sel_b_n = VEC[i].sb_n; sel_c = VEC[i].sc;
      adv_burst = VEC[i].adv; rd_nwr = VEC[i].rnw; lane_wr_n = VEC[i].bw_n;
      addr = VEC[i].a; bus_in = VEC[i].d;
      @(posedge clk); #1;
      chk($sformatf("R%0d vec %0d oe", VEC[i].req, i), {35'b0, bus_oe}, {35'b0, VEC[i].e_oe});
      if (VEC[i].e_oe)
        chk($sformatf("R%0d vec %0d data", VEC[i].req, i), bus_out, VEC[i].e_out);
    end

    // R4 lanes: clear word 9, write lanes 0 and 2, then a write with no lanes
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 36'h0, 4'hF);
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 36'h0, 4'hF);
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 36'h0, 4'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'hFFFFFFFFF, 4'b1010);
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd9, 36'h123456789, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);
    chk("R4 lane mask", bus_out, lane_mask(4'b1010));

    // R9 forwarding: full word, then lane 0 only
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd12, 36'h0, 4'hF);
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd12, 36'h0, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h987654321, 4'h0);
    chk("R9 forward full", bus_out, 36'h987654321);
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd12, 36'h0, 4'hF);
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd12, 36'h0, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'b1110);
    chk("R9 forward lane0", bus_out, 36'h987654200);

    // R8 suspend with a read on the bus
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd9, 36'h0, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);
    chk("R8 before hold", {35'b0, bus_oe}, 36'h1);
    for (int k = 0; k < 3; k++) begin
      op(1'b1, 1'b1, 1'b0, 1'b0, 6'd12, 36'hFFFFFFFFF, 4'h0);
      chk("R8 held oe", {35'b0, bus_oe}, 36'h1);
      chk("R8 held data", bus_out, lane_mask(4'b1010));
    end
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);
    chk("R8 resume", {35'b0, bus_oe}, 36'h0);

    // R8 suspend inside a write's window shifts its data edge
    op(1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 36'h0, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);
    op(1'b1, 1'b0, 1'b0, 1'b1, 6'd0, 36'h111111111, 4'h0);
    op(1'b1, 1'b0, 1'b0, 1'b1, 6'd0, 36'h222222222, 4'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h3C3C3C3C3, 4'h0);
    op(1'b0, 1'b1, 1'b0, 1'b1, 6'd20, 36'h0, 4'hF);
    op(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 36'h0, 4'hF);
    chk("R8 write after hold", bus_out, 36'h3C3C3C3C3);
    chk("R3 write after hold oe", {35'b0, bus_oe}, 36'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule